// File: doc/BRIEF.md
# Two-Group Vectored Interrupt Controller with Daisy Chain

This block gathers interrupt requests from eight receive channels and three transmit channels and raises one interrupt line per group. Each channel's request is latched as a pending bit when the channel pulses its request input. The bit stays set until the host writes a one to the matching bit of the group's clear register. A per-channel mask bit keeps a pending channel from reaching the group line, and the pending bit is kept while the channel is masked.

Each group sits on its own daisy chain and has a chain-enable input and a chain-enable output. While a group has no unmasked pending channel, it passes the enable down the chain. When the host acknowledges a group whose chain enable is high and which has an unmasked pending channel, the group keeps the acknowledge and drives a vector. The vector is the group's programmable base with the serviced channel's index in the low bits. The receive group chooses its channel by a rotating priority whose starting channel can be programmed. The transmit group uses a fixed priority.

Top module: `irq_vector_ctrl`

## Requirements
- R1: After reset all pending bits, masks, bases and the receive start channel are zero. Both irq outputs are low, vec_valid is low, vec_out is zero, and each ieo output follows its iei input.
- R2: A one on bit i of rx_set or tx_set sets pending bit i on the next clock edge. The bit stays set until a register write to address 4 (receive) or address 5 (transmit) carries a one in data bit i. Zero bits in such a write leave their channels pending.
- R3: When a set pulse and a clear write reach the same channel in the same cycle, the channel is still pending afterwards.
- R4: Mask registers sit at address 2 (receive, data bits 7:0) and address 3 (transmit, data bits 2:0). A mask bit of one keeps that channel out of the irq line and out of the vector choice. Its pending bit is kept and takes effect again once the mask bit is cleared.
- R5: rx_irq is high exactly when some receive channel is pending and unmasked. tx_irq follows the same rule for the transmit channels. The two groups do not affect each other.
- R6: For each group, ieo equals iei AND NOT irq of that group.
- R7: vec_valid is high when iack_rx, rx_iei and rx_irq are all high, or when iack_tx, tx_iei and tx_irq are all high. Otherwise vec_valid is low and vec_out is zero.
- R8: The receive vector is bits 7:3 of the base at address 0 followed by the 3-bit channel index. The receive start channel is written at address 6 (data bits 2:0). The receive channel picked is the first unmasked pending channel found by counting upward from the start channel and wrapping after channel 7.
- R9: The transmit vector is bits 7:2 of the base at address 1 followed by the 2-bit channel index. The transmit channel picked is the lowest-numbered unmasked pending channel.
- R10: When both groups claim an acknowledge in the same cycle, the receive vector is driven.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| rx_set | input | 8 | Receive channel request pulses |
| tx_set | input | 3 | Transmit channel request pulses |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 3 | Register address |
| wr_data | input | 8 | Register write data |
| iack_rx | input | 1 | Host acknowledge of the receive line |
| iack_tx | input | 1 | Host acknowledge of the transmit line |
| rx_iei | input | 1 | Receive chain enable in |
| tx_iei | input | 1 | Transmit chain enable in |
| rx_irq | output | 1 | Receive group interrupt request |
| tx_irq | output | 1 | Transmit group interrupt request |
| rx_ieo | output | 1 | Receive chain enable out |
| tx_ieo | output | 1 | Transmit chain enable out |
| vec_out | output | 8 | Vector for the acknowledged channel |
| vec_valid | output | 1 | Vector is being driven |

## Verification
The receive picker is swept over every non-empty pending pattern under every start channel. This separates a rotating search from a fixed one and catches any slip in the wrap-around. A second sweep holds all receive channels pending and steps through all 256 masks. It shows whether masking suppresses a channel, whether it drops the pending state, and whether unmasking restores it. The transmit group is swept over every pending pattern against every mask. Directed cases then cover partial clears, a set and a clear in the same cycle, a chain enable that is low, a group with nothing pending, and both groups claiming at once.

// File: rtl/irqv_pkg.sv
package irqv_pkg;
  localparam int VEC_W = 8;

  typedef enum logic [2:0] {
    REG_RX_BASE = 3'd0,
    REG_TX_BASE = 3'd1,
    REG_RX_MASK = 3'd2,
    REG_TX_MASK = 3'd3,
    REG_RX_CLR  = 3'd4,
    REG_TX_CLR  = 3'd5,
    REG_RX_TOP  = 3'd6
  } reg_sel_e;
endpackage

// File: rtl/irqv_pend_bank.sv
module irqv_pend_bank #(
  parameter int N = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] set,
  input  logic [N-1:0] clr,
  input  logic [N-1:0] mask,
  output logic [N-1:0] pend,
  output logic [N-1:0] live,
  output logic         any
);
  logic [N-1:0] pend_q;

  // A set pulse takes priority over a clear that arrives in the same cycle.
  function automatic logic [N-1:0] next_pend(input logic [N-1:0] cur,
                                             input logic [N-1:0] s,
                                             input logic [N-1:0] c);
    return (cur & ~c) | s;
  endfunction

  always_ff @(posedge clk) begin
    if (!rst_n) pend_q <= '0;
    else        pend_q <= next_pend(pend_q, set, clr);
  end

  assign pend = pend_q;
  assign live = pend_q & ~mask;
  assign any  = |live;

  assert_set_lands_R2: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ((pend & $past(set)) == $past(set)));
  assert_set_beats_clear_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (|(set & clr)) |=> ((pend & $past(set & clr)) == $past(set & clr)));
  assert_mask_keeps_pend_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (set == '0 && clr == '0) |=> $stable(pend));
endmodule

// File: rtl/irqv_prio_pick.sv
module irqv_prio_pick #(
  parameter int N      = 8,
  parameter int IW     = 3,
  parameter bit ROTATE = 1'b1
) (
  input  logic [N-1:0]  req,
  input  logic [IW-1:0] top,
  output logic          hit,
  output logic [IW-1:0] idx
);
  // Scans from 'start' upward with wrap; the lowest offset wins.
  function automatic logic [IW-1:0] first_from(input logic [N-1:0] r, input int start);
    logic [IW-1:0] res;
    res = '0;
    for (int k = N - 1; k >= 0; k--) begin
      int c;
      c = (start + k) % N;
      if (r[c]) res = IW'(c);
    end
    return res;
  endfunction

  logic [IW-1:0] start_sel;

  generate
    if (ROTATE) begin : g_rot
      assign start_sel = top;
    end else begin : g_fixed
      assign start_sel = '0;
    end
  endgenerate

  assign hit = |req;
  assign idx = first_from(req, int'(start_sel));

  always_comb begin
    if (hit) assert_pick_is_pending_R8: assert (req[idx]);
  end
endmodule

// File: rtl/irqv_chain.sv
module irqv_chain #(
  parameter int IW    = 3,
  parameter int VEC_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             iack,
  input  logic             iei,
  input  logic             irq,
  input  logic [IW-1:0]    idx,
  input  logic [VEC_W-1:0] base,
  output logic             ieo,
  output logic             claim,
  output logic [VEC_W-1:0] vec
);
  function automatic logic [VEC_W-1:0] make_vec(input logic [VEC_W-1:0] b,
                                                input logic [IW-1:0] i);
    return {b[VEC_W-1:IW], i};
  endfunction

  assign ieo   = iei & ~irq;
  assign claim = iack & iei & irq;
  assign vec   = make_vec(base, idx);

  assert_claim_blocks_chain_R6: assert property (@(posedge clk) disable iff (!rst_n)
    claim |-> !ieo);
  assert_no_claim_without_enable_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !iei |-> (!claim && !ieo));
endmodule

// File: rtl/irq_vector_ctrl.sv
module irq_vector_ctrl
  import irqv_pkg::*;
#(
  parameter int RX_CH = 8,
  parameter int TX_CH = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [RX_CH-1:0] rx_set,
  input  logic [TX_CH-1:0] tx_set,
  input  logic             wr_en,
  input  logic [2:0]       wr_addr,
  input  logic [VEC_W-1:0] wr_data,
  input  logic             iack_rx,
  input  logic             iack_tx,
  input  logic             rx_iei,
  input  logic             tx_iei,
  output logic             rx_irq,
  output logic             tx_irq,
  output logic             rx_ieo,
  output logic             tx_ieo,
  output logic [VEC_W-1:0] vec_out,
  output logic             vec_valid
);
  localparam int RX_IW = $clog2(RX_CH);
  localparam int TX_IW = $clog2(TX_CH);

  logic [VEC_W-1:0] rx_base_q, tx_base_q;
  logic [RX_CH-1:0] rx_mask_q;
  logic [TX_CH-1:0] tx_mask_q;
  logic [RX_IW-1:0] rx_top_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rx_base_q <= '0;
      tx_base_q <= '0;
      rx_mask_q <= '0;
      tx_mask_q <= '0;
      rx_top_q  <= '0;
    end else if (wr_en) begin
      case (reg_sel_e'(wr_addr))
        REG_RX_BASE: rx_base_q <= wr_data;
        REG_TX_BASE: tx_base_q <= wr_data;
        REG_RX_MASK: rx_mask_q <= wr_data[RX_CH-1:0];
        REG_TX_MASK: tx_mask_q <= wr_data[TX_CH-1:0];
        REG_RX_TOP:  rx_top_q  <= wr_data[RX_IW-1:0];
        default: ;
      endcase
    end
  end

  logic [RX_CH-1:0] rx_clr_w, rx_pend_w, rx_live_w;
  logic [TX_CH-1:0] tx_clr_w, tx_pend_w, tx_live_w;
  logic             rx_any_w, tx_any_w;

  assign rx_clr_w = (wr_en && reg_sel_e'(wr_addr) == REG_RX_CLR) ? wr_data[RX_CH-1:0] : '0;
  assign tx_clr_w = (wr_en && reg_sel_e'(wr_addr) == REG_TX_CLR) ? wr_data[TX_CH-1:0] : '0;

  irqv_pend_bank #(.N(RX_CH)) u_rx_bank (
    .clk(clk), .rst_n(rst_n), .set(rx_set), .clr(rx_clr_w), .mask(rx_mask_q),
    .pend(rx_pend_w), .live(rx_live_w), .any(rx_any_w));
  irqv_pend_bank #(.N(TX_CH)) u_tx_bank (
    .clk(clk), .rst_n(rst_n), .set(tx_set), .clr(tx_clr_w), .mask(tx_mask_q),
    .pend(tx_pend_w), .live(tx_live_w), .any(tx_any_w));

  logic             rx_hit_w, tx_hit_w;
  logic [RX_IW-1:0] rx_idx_w;
  logic [TX_IW-1:0] tx_idx_w;

  irqv_prio_pick #(.N(RX_CH), .IW(RX_IW), .ROTATE(1'b1)) u_rx_pick (
    .req(rx_live_w), .top(rx_top_q), .hit(rx_hit_w), .idx(rx_idx_w));
  irqv_prio_pick #(.N(TX_CH), .IW(TX_IW), .ROTATE(1'b0)) u_tx_pick (
    .req(tx_live_w), .top('0), .hit(tx_hit_w), .idx(tx_idx_w));

  logic             rx_claim_w, tx_claim_w;
  logic [VEC_W-1:0] rx_vec_w, tx_vec_w;

  irqv_chain #(.IW(RX_IW), .VEC_W(VEC_W)) u_rx_chain (
    .clk(clk), .rst_n(rst_n), .iack(iack_rx), .iei(rx_iei), .irq(rx_any_w),
    .idx(rx_idx_w), .base(rx_base_q), .ieo(rx_ieo), .claim(rx_claim_w), .vec(rx_vec_w));
  irqv_chain #(.IW(TX_IW), .VEC_W(VEC_W)) u_tx_chain (
    .clk(clk), .rst_n(rst_n), .iack(iack_tx), .iei(tx_iei), .irq(tx_any_w),
    .idx(tx_idx_w), .base(tx_base_q), .ieo(tx_ieo), .claim(tx_claim_w), .vec(tx_vec_w));

  assign rx_irq    = rx_any_w;
  assign tx_irq    = tx_any_w;
  assign vec_valid = rx_claim_w | tx_claim_w;
  assign vec_out   = rx_claim_w ? rx_vec_w : (tx_claim_w ? tx_vec_w : '0);

  assert_irq_matches_hit_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_irq == rx_hit_w) && (tx_irq == tx_hit_w));
  assert_valid_needs_ack_R7: assert property (@(posedge clk) disable iff (!rst_n)
    vec_valid |-> (iack_rx || iack_tx));
  assert_rx_wins_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_claim_w && tx_claim_w) |-> (vec_out[RX_IW-1:0] == rx_idx_w));
  assert_idle_vec_zero_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !vec_valid |-> (vec_out == '0));
endmodule

// File: tb/irq_vector_ctrl_bench.sv
module irq_vector_ctrl_bench;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [7:0] rx_set = '0;
  logic [2:0] tx_set = '0;
  logic       wr_en = 1'b0;
  logic [2:0] wr_addr = '0;
  logic [7:0] wr_data = '0;
  logic       iack_rx = 1'b0, iack_tx = 1'b0, rx_iei = 1'b1, tx_iei = 1'b1;
  logic       rx_irq, tx_irq, rx_ieo, tx_ieo, vec_valid;
  logic [7:0] vec_out;

  int total = 0;
  int bad = 0;
  bit done = 1'b0;

  localparam logic [7:0] RXB = 8'hA5;
  localparam logic [7:0] TXB = 8'h6F;

  always #10 clk = ~clk;

  irq_vector_ctrl u_irq_vector_ctrl (
    .clk(clk), .rst_n(rst_n), .rx_set(rx_set), .tx_set(tx_set), .wr_en(wr_en),
    .wr_addr(wr_addr), .wr_data(wr_data), .iack_rx(iack_rx), .iack_tx(iack_tx),
    .rx_iei(rx_iei), .tx_iei(tx_iei), .rx_irq(rx_irq), .tx_irq(tx_irq),
    .rx_ieo(rx_ieo), .tx_ieo(tx_ieo), .vec_out(vec_out), .vec_valid(vec_valid));

  task automatic check(input string tag, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [7:0] d);
    @(negedge clk); wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk); wr_en = 1'b0; #1;
  endtask

  task automatic pulse(input logic [7:0] r, input logic [2:0] t);
    @(negedge clk); rx_set = r; tx_set = t;
    @(negedge clk); rx_set = '0; tx_set = '0; #1;
  endtask

  // Receive model: first unmasked pending channel counting up from start.
  function automatic int rx_model(input logic [7:0] p, input logic [7:0] m, input int start);
    for (int k = 0; k < 8; k++) begin
      int c;
      c = (start + k) % 8;
      if (p[c] && !m[c]) return c;
    end
    return -1;
  endfunction

  function automatic int tx_model(input logic [2:0] p, input logic [2:0] m);
    for (int c = 0; c < 3; c++) if (p[c] && !m[c]) return c;
    return -1;
  endfunction

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      bad++; total++;
      $display("FAIL watchdog actual=hung expected=finish");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1; #1;
    // R1: reset state
    check("R1 rx_irq", rx_irq, 0);
    check("R1 tx_irq", tx_irq, 0);
    check("R1 vec_valid", vec_valid, 0);
    check("R1 vec_out", vec_out, 0);
    check("R1 rx_ieo", rx_ieo, 1);
    rx_iei = 1'b0; tx_iei = 1'b0; #1;
    check("R1 ieo follows iei", {rx_ieo, tx_ieo}, 0);
    rx_iei = 1'b1; tx_iei = 1'b1;

    wr(3'd0, RXB);
    wr(3'd1, TXB);

    // R8 sweep: every pending pattern under every start channel
    iack_rx = 1'b1;
    for (int p = 1; p < 256; p++) begin
      pulse(8'(p), 3'd0);
      for (int t = 0; t < 8; t++) begin
        wr(3'd6, 8'(t));
        check("R8 vector", vec_out, int'({RXB[7:3], 3'(rx_model(8'(p), 8'h00, t))}));
        check("R7 valid", vec_valid, 1);
      end
      wr(3'd4, 8'hFF);
      check("R2 cleared", rx_irq, 0);
    end
    wr(3'd6, 8'd0);

    // R4 sweep: all pending, every mask
    pulse(8'hFF, 3'd0);
    for (int m = 0; m < 256; m++) begin
      wr(3'd2, 8'(m));
      check("R4 rx_irq", rx_irq, (m != 255) ? 1 : 0);
      if (m != 255)
        check("R4 vector", vec_out, int'({RXB[7:3], 3'(rx_model(8'hFF, 8'(m), 0))}));
      else
        check("R4 masked vec", vec_valid, 0);
    end
    wr(3'd2, 8'h00);
    check("R4 restored", vec_out, int'({RXB[7:3], 3'd0}));
    check("R5 tx quiet", tx_irq, 0);
    wr(3'd4, 8'hFF);

    // R2 partial clears
    pulse(8'h0F, 3'd0);
    wr(3'd4, 8'h05);
    check("R2 partial", vec_out, int'({RXB[7:3], 3'd1}));
    wr(3'd4, 8'h02);
    check("R2 partial2", vec_out, int'({RXB[7:3], 3'd3}));
    wr(3'd4, 8'h08);
    check("R2 empty", rx_irq, 0);

    // R3 set and clear in the same cycle
    @(negedge clk); rx_set = 8'h01; wr_en = 1'b1; wr_addr = 3'd4; wr_data = 8'h01;
    @(negedge clk); rx_set = '0; wr_en = 1'b0; #1;
    check("R3 set wins", rx_irq, 1);

    // R6 / R7 chain behaviour
    rx_iei = 1'b0; #1;
    check("R6 ieo low when iei low", rx_ieo, 0);
    check("R7 no claim without iei", vec_valid, 0);
    rx_iei = 1'b1; #1;
    check("R6 ieo low when pending", rx_ieo, 0);
    iack_rx = 1'b0; #1;
    check("R7 no claim without iack", vec_valid, 0);
    wr(3'd4, 8'h01);
    check("R6 pass through", rx_ieo, 1);

    // R9 transmit sweep: every pattern against every mask
    iack_tx = 1'b1;
    for (int p = 1; p < 8; p++) begin
      pulse(8'd0, 3'(p));
      for (int m = 0; m < 8; m++) begin
        wr(3'd3, 8'(m));
        if (tx_model(3'(p), 3'(m)) >= 0) begin
          check("R9 tx vector", vec_out, int'({TXB[7:2], 2'(tx_model(3'(p), 3'(m)))}));
          check("R5 tx_irq", tx_irq, 1);
        end else begin
          check("R5 tx_irq masked", tx_irq, 0);
          check("R6 tx pass", tx_ieo, 1);
        end
        check("R5 rx quiet", rx_irq, 0);
      end
      wr(3'd3, 8'h00);
      wr(3'd5, 8'h07);
      check("R2 tx cleared", tx_irq, 0);
    end

    // R10 both groups claim together
    pulse(8'h40, 3'b100);
    iack_rx = 1'b1; #1;
    check("R10 rx wins", vec_out, int'({RXB[7:3], 3'd6}));
    iack_rx = 1'b0; #1;
    check("R10 tx alone", vec_out, int'({TXB[7:2], 2'd2}));

    done = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule